// File: doc/BRIEF.md
# Mode-Switched Operand Store

This block is the operand storage of a teaching processor that can take on one of six architecture styles. A single array of eight 16-bit entries serves, according to a 3-bit architecture select, as an eight-entry general register file, as an eight-deep operand stack, or as an accumulator. In the extended-accumulator style it serves as an accumulator plus three indexed helper registers. In the memory-to-memory style no storage is visible. The ALU, memory and instruction decoding sit outside this block.

The processor drives a command code, a write index, write data and two read indices every cycle. The two read ports are combinational views of the storage as seen through the active architecture. Any command that the active architecture does not define is ignored. The stack reports its empty and full levels continuously. It raises a one-cycle overflow or underflow pulse when a stack command is refused.

Every pin is plain control or data with no flow control. The block accepts one command on each rising clock edge and never stalls. The architecture select is captured on each rising edge. When the value at an edge differs from the captured one, that edge clears the stack depth and entry 0, drops the command presented with it, and makes the new architecture active from the next cycle.

Top module: `mode_store_unit`

## Requirements
- R1: After the asynchronous active-low reset, every entry and the stack depth are zero, the active architecture is memory-to-memory (code 0), both error pulses are low, the empty flag is high and the full flag is low.
- R2: The architecture codes are 0 memory-to-memory, 1 accumulator, 2 extended accumulator, 3 stack, 4 register-memory, 5 load-store, with 6 and 7 unused. A select value that differs from the active one at a rising edge clears the stack depth and entry 0, discards that cycle's command, and becomes active after that edge. Entries 1 to 7 keep their contents.
- R3: In codes 4 and 5, command 1 (register write) stores wr_data in entry wr_idx at the edge. rd_data_a and rd_data_b show entries rd_idx_a and rd_idx_b.
- R4: In code 1, command 2 (accumulator load) stores wr_data in entry 0. rd_data_a shows entry 0 (the accumulator store path) and rd_data_b reads zero.
- R5: In code 2, command 2 loads entry 0 and command 1 writes entry wr_idx only for indices 1 to 3, so index 0 or 4 to 7 is ignored. rd_data_a shows entry 0, and rd_data_b shows entry rd_idx_b for indices 0 to 3 and zero otherwise.
- R6: In code 3, rd_data_a shows the top of stack and rd_data_b the entry below it, each reading zero when that entry does not exist. stk_empty is high at depth 0 and stk_full is high at depth 8.
- R7: In code 3, command 3 (push) places wr_data on top and command 4 (pop) removes the top entry.
- R8: In code 3, command 5 (duplicate) pushes a copy of the top entry and command 6 (swap) exchanges the top two entries.
- R9: In code 3, command 7 (rotate) brings the third entry to the top and moves the former top and second entries down by one place each.
- R10: Pop or duplicate at depth 0, swap below depth 2, and rotate below depth 3 leave the stack unchanged and pulse unf_err high for the cycle after that edge.
- R11: Push at depth 8, and duplicate at depth 8 with at least one entry present, leave the stack unchanged and pulse ovf_err high for the cycle after that edge.
- R12: In codes 0, 6 and 7 every command is ignored and both read ports read zero.
- R13: A command that the active architecture does not define, such as a push in a register mode or an accumulator load in the stack mode, changes no storage and raises no error pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arch_sel | input | 3 | Architecture select (codes in R2) |
| cmd | input | 3 | Command: 0 none, 1 register write, 2 accumulator load, 3 push, 4 pop, 5 duplicate, 6 swap, 7 rotate |
| wr_idx | input | 3 | Entry index for register write |
| wr_data | input | 16 | Data for register write, accumulator load and push |
| rd_idx_a | input | 3 | Read index of port A in register modes |
| rd_idx_b | input | 3 | Read index of port B in register and extended-accumulator modes |
| rd_data_a | output | 16 | Read port A |
| rd_data_b | output | 16 | Read port B |
| stk_empty | output | 1 | Stack depth is zero |
| stk_full | output | 1 | Stack depth is eight |
| ovf_err | output | 1 | One-cycle pulse after a refused stack growth |
| unf_err | output | 1 | One-cycle pulse after a stack command with too few entries |

## Verification
The assertions assume that arch_sel, cmd and the indices are free of X and stable around each rising edge. They also assume that a command presented on the same edge as an architecture change is dropped rather than executed under either architecture. The stimulus changes every input only at the falling edge and draws them from full-width unsigned ranges, so no X enters. Architecture changes are rare and random, with commands freely mixed in. In stack mode the command draw favours pushes, so random runs reach the full level as well as the empty one.

// File: rtl/asu_pkg.sv
package asu_pkg;

  localparam logic [2:0] ARCH_MEMMEM = 3'd0;
  localparam logic [2:0] ARCH_ACC    = 3'd1;
  localparam logic [2:0] ARCH_XACC   = 3'd2;
  localparam logic [2:0] ARCH_STACK  = 3'd3;
  localparam logic [2:0] ARCH_REGMEM = 3'd4;
  localparam logic [2:0] ARCH_LDST   = 3'd5;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_REG_WR = 3'd1,
    CMD_ACC_LD = 3'd2,
    CMD_PUSH   = 3'd3,
    CMD_POP    = 3'd4,
    CMD_DUP    = 3'd5,
    CMD_SWAP   = 3'd6,
    CMD_ROT3   = 3'd7
  } cmd_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic dup;
    logic swap;
    logic rot;
  } stk_op_t;

endpackage

// File: rtl/asu_stkptr.sv
module asu_stkptr
  import asu_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int SPW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  stk_op_t        req,
  output logic [SPW-1:0] sp,
  output stk_op_t        grant,
  output logic           ovf_err,
  output logic           unf_err
);

  localparam logic [SPW-1:0] SP_MAX = SPW'(DEPTH);

  logic           ovf_n, unf_n;
  logic [SPW-1:0] sp_n;

  always_comb begin
    grant = '0;
    ovf_n = 1'b0;
    unf_n = 1'b0;
    if (req.push) begin
      if (sp == SP_MAX) ovf_n = 1'b1;
      else              grant.push = 1'b1;
    end
    if (req.pop) begin
      if (sp == '0) unf_n = 1'b1;
      else          grant.pop = 1'b1;
    end
    if (req.dup) begin
      if (sp == '0)          unf_n = 1'b1;
      else if (sp == SP_MAX) ovf_n = 1'b1;
      else                   grant.dup = 1'b1;
    end
    if (req.swap) begin
      if (sp < SPW'(2)) unf_n = 1'b1;
      else              grant.swap = 1'b1;
    end
    if (req.rot) begin
      if (sp < SPW'(3)) unf_n = 1'b1;
      else              grant.rot = 1'b1;
    end
  end

  always_comb begin
    sp_n = sp;
    if (grant.push || grant.dup) sp_n = sp + SPW'(1);
    else if (grant.pop)          sp_n = sp - SPW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp      <= '0;
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      sp      <= clr ? '0 : sp_n;
      ovf_err <= ovf_n;
      unf_err <= unf_n;
    end
  end

  AST_SP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_MAX); // R6
  AST_PUSH_FULL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req.push && !clr && sp == SP_MAX) |=> (ovf_err && sp == SP_MAX)); // R11
  AST_POP_EMPTY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req.pop && !clr && sp == '0) |=> (unf_err && sp == '0)); // R10
  AST_ONE_ERROR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_err && unf_err)); // R10

endmodule

// File: rtl/asu_array.sv
module asu_array
  import asu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int IW  = $clog2(DEPTH),
  localparam int SPW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_acc,
  input  logic             reg_we,
  input  logic [IW-1:0]    reg_idx,
  input  logic             acc_we,
  input  logic [WIDTH-1:0] wdata,
  input  stk_op_t          grant,
  input  logic [SPW-1:0]   sp,
  output logic [WIDTH-1:0] ent [DEPTH]
);

  logic [WIDTH-1:0] mem_d [DEPTH];
  logic [IW-1:0]    tn, t1, t2, t3;

  assign tn = IW'(sp);
  assign t1 = IW'(sp - SPW'(1));
  assign t2 = IW'(sp - SPW'(2));
  assign t3 = IW'(sp - SPW'(3));

  always_comb begin
    mem_d = ent;
    if (grant.push) mem_d[tn] = wdata;
    if (grant.dup)  mem_d[tn] = ent[t1];
    if (grant.swap) begin
      mem_d[t1] = ent[t2];
      mem_d[t2] = ent[t1];
    end
    if (grant.rot) begin
      mem_d[t1] = ent[t3];
      mem_d[t2] = ent[t1];
      mem_d[t3] = ent[t2];
    end
    if (reg_we)  mem_d[reg_idx] = wdata;
    if (acc_we)  mem_d[0] = wdata;
    if (clr_acc) mem_d[0] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= mem_d[i];
    end
  end

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_acc |=> (ent[0] == '0)); // R2

endmodule

// File: rtl/asu_rdmux.sv
module asu_rdmux
  import asu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  parameter int XREGS = 4,
  localparam int IW  = $clog2(DEPTH),
  localparam int SPW = $clog2(DEPTH + 1)
) (
  input  logic [2:0]       arch,
  input  logic [WIDTH-1:0] ent [DEPTH],
  input  logic [SPW-1:0]   sp,
  input  logic [IW-1:0]    idx_a,
  input  logic [IW-1:0]    idx_b,
  output logic [WIDTH-1:0] data_a,
  output logic [WIDTH-1:0] data_b
);

  logic [IW-1:0] top_i, nxt_i;
  logic          b_in_xregs;

  assign top_i      = IW'(sp - SPW'(1));
  assign nxt_i      = IW'(sp - SPW'(2));
  assign b_in_xregs = ({1'b0, idx_b} < (IW + 1)'(XREGS));

  always_comb begin
    data_a = '0;
    data_b = '0;
    case (arch)
      ARCH_REGMEM, ARCH_LDST: begin
        data_a = ent[idx_a];
        data_b = ent[idx_b];
      end
      ARCH_ACC: data_a = ent[0];
      ARCH_XACC: begin
        data_a = ent[0];
        if (b_in_xregs) data_b = ent[idx_b];
      end
      ARCH_STACK: begin
        if (sp >= SPW'(1)) data_a = ent[top_i];
        if (sp >= SPW'(2)) data_b = ent[nxt_i];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mode_store_unit.sv
module mode_store_unit
  import asu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  parameter int XREGS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               arch_sel,
  input  logic [2:0]               cmd,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx_a,
  input  logic [$clog2(DEPTH)-1:0] rd_idx_b,
  output logic [WIDTH-1:0]         rd_data_a,
  output logic [WIDTH-1:0]         rd_data_b,
  output logic                     stk_empty,
  output logic                     stk_full,
  output logic                     ovf_err,
  output logic                     unf_err
);

  localparam int IW  = $clog2(DEPTH);
  localparam int SPW = $clog2(DEPTH + 1);

  logic [2:0]       arch_q;
  logic             switch_w;
  cmd_e             cmd_eff;
  logic             is_reg, is_acc, is_xacc, is_stk;
  logic             xidx_ok, reg_we, acc_we;
  stk_op_t          req, grant;
  logic [SPW-1:0]   sp;
  logic [WIDTH-1:0] ent [DEPTH];

  assign switch_w = (arch_sel != arch_q);
  assign cmd_eff  = switch_w ? CMD_NOP : cmd_e'(cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arch_q <= ARCH_MEMMEM;
    else        arch_q <= arch_sel;
  end

  assign is_reg  = (arch_q == ARCH_REGMEM) || (arch_q == ARCH_LDST);
  assign is_acc  = (arch_q == ARCH_ACC);
  assign is_xacc = (arch_q == ARCH_XACC);
  assign is_stk  = (arch_q == ARCH_STACK);

  assign xidx_ok = (wr_idx != '0) && ({1'b0, wr_idx} < (IW + 1)'(XREGS));
  assign reg_we  = (cmd_eff == CMD_REG_WR) && (is_reg || (is_xacc && xidx_ok));
  assign acc_we  = (cmd_eff == CMD_ACC_LD) && (is_acc || is_xacc);

  assign req.push = is_stk && (cmd_eff == CMD_PUSH);
  assign req.pop  = is_stk && (cmd_eff == CMD_POP);
  assign req.dup  = is_stk && (cmd_eff == CMD_DUP);
  assign req.swap = is_stk && (cmd_eff == CMD_SWAP);
  assign req.rot  = is_stk && (cmd_eff == CMD_ROT3);

  asu_stkptr #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (switch_w),
    .req     (req),
    .sp      (sp),
    .grant   (grant),
    .ovf_err (ovf_err),
    .unf_err (unf_err)
  );

  asu_array #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_acc (switch_w),
    .reg_we  (reg_we),
    .reg_idx (wr_idx),
    .acc_we  (acc_we),
    .wdata   (wr_data),
    .grant   (grant),
    .sp      (sp),
    .ent     (ent)
  );

  asu_rdmux #(.WIDTH(WIDTH), .DEPTH(DEPTH), .XREGS(XREGS)) u_rdmux (
    .arch   (arch_q),
    .ent    (ent),
    .sp     (sp),
    .idx_a  (rd_idx_a),
    .idx_b  (rd_idx_b),
    .data_a (rd_data_a),
    .data_b (rd_data_b)
  );

  assign stk_empty = (sp == '0);
  assign stk_full  = (sp == SPW'(DEPTH));

  AST_PUSH_SHOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (is_stk && cmd_eff == CMD_PUSH && !stk_full) |=> (rd_data_a == $past(wr_data))); // R7
  AST_SWITCH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    switch_w |=> stk_empty); // R2
  AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (arch_q == ARCH_MEMMEM || arch_q > ARCH_LDST) |-> (rd_data_a == '0 && rd_data_b == '0)); // R12
  AST_ACC_PORT_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    is_acc |-> (rd_data_b == '0)); // R4

endmodule

// File: tb/mode_store_unit_test.sv
module mode_store_unit_test;

  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] A_MM = 3'd0, A_ACC = 3'd1, A_XA = 3'd2, A_STK = 3'd3,
                         A_RM = 3'd4, A_LS = 3'd5;
  localparam logic [2:0] C_NOP = 3'd0, C_WR = 3'd1, C_LD = 3'd2, C_PUSH = 3'd3,
                         C_POP = 3'd4, C_DUP = 3'd5, C_SWAP = 3'd6, C_ROT = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  arch_sel, cmd, wr_idx, rd_idx_a, rd_idx_b;
  logic [15:0] wr_data, rd_data_a, rd_data_b;
  logic        stk_empty, stk_full, ovf_err, unf_err;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [15:0] m_mem [8];
  int          m_sp;
  logic [2:0]  m_arch;
  logic        m_ovf, m_unf;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mode_store_unit uut (
    .clk (clk), .rst_n (rst_n), .arch_sel (arch_sel), .cmd (cmd),
    .wr_idx (wr_idx), .wr_data (wr_data), .rd_idx_a (rd_idx_a), .rd_idx_b (rd_idx_b),
    .rd_data_a (rd_data_a), .rd_data_b (rd_data_b), .stk_empty (stk_empty),
    .stk_full (stk_full), .ovf_err (ovf_err), .unf_err (unf_err)
  );

  function automatic logic [15:0] exp_a(logic [2:0] ia);
    case (m_arch)
      A_RM, A_LS:  return m_mem[ia];
      A_ACC, A_XA: return m_mem[0];
      A_STK:       return (m_sp >= 1) ? m_mem[m_sp - 1] : 16'h0;
      default:     return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] exp_b(logic [2:0] ib);
    case (m_arch)
      A_RM, A_LS: return m_mem[ib];
      A_XA:       return (ib < 3'd4) ? m_mem[ib] : 16'h0;
      A_STK:      return (m_sp >= 2) ? m_mem[m_sp - 2] : 16'h0;
      default:    return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      A_RM, A_LS: return "R3";
      A_ACC:      return "R4";
      A_XA:       return "R5";
      A_STK:      return "R6";
      default:    return "R12";
    endcase
  endfunction

  task automatic model_step(logic [2:0] a, logic [2:0] c, logic [2:0] wi, logic [15:0] wd);
    logic [15:0] x, y, z;
    m_ovf = 1'b0;
    m_unf = 1'b0;
    if (a != m_arch) begin
      m_arch   = a;
      m_sp     = 0;
      m_mem[0] = 16'h0;
      return;
    end
    case (m_arch)
      A_RM, A_LS: if (c == C_WR) m_mem[wi] = wd;
      A_ACC:      if (c == C_LD) m_mem[0] = wd;
      A_XA: begin
        if (c == C_LD) m_mem[0] = wd;
        else if (c == C_WR && wi >= 3'd1 && wi <= 3'd3) m_mem[wi] = wd;
      end
      A_STK: begin
        case (c)
          C_PUSH: if (m_sp == 8) m_ovf = 1'b1;
                  else begin m_mem[m_sp] = wd; m_sp++; end
          C_POP:  if (m_sp == 0) m_unf = 1'b1; else m_sp--;
          C_DUP:  if (m_sp == 0) m_unf = 1'b1;
                  else if (m_sp == 8) m_ovf = 1'b1;
                  else begin m_mem[m_sp] = m_mem[m_sp - 1]; m_sp++; end
          C_SWAP: if (m_sp < 2) m_unf = 1'b1;
                  else begin
                    x = m_mem[m_sp - 1];
                    m_mem[m_sp - 1] = m_mem[m_sp - 2];
                    m_mem[m_sp - 2] = x;
                  end
          C_ROT:  if (m_sp < 3) m_unf = 1'b1;
                  else begin
                    x = m_mem[m_sp - 1]; y = m_mem[m_sp - 2]; z = m_mem[m_sp - 3];
                    m_mem[m_sp - 1] = z;
                    m_mem[m_sp - 2] = x;
                    m_mem[m_sp - 3] = y;
                  end
          default: ;
        endcase
      end
      default: ;
    endcase
  endtask

  task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // Drive one command; outputs are checked against the state before this edge.
  task automatic step(string tag, logic [2:0] a, logic [2:0] c, logic [2:0] wi,
                      logic [15:0] wd, logic [2:0] ia, logic [2:0] ib);
    @(negedge clk);
    arch_sel = a; cmd = c; wr_idx = wi; wr_data = wd; rd_idx_a = ia; rd_idx_b = ib;
    #1;
    check(tag, "rd_data_a", rd_data_a, exp_a(ia));
    check(tag, "rd_data_b", rd_data_b, exp_b(ib));
    check(tag, "stk_empty", {15'h0, stk_empty}, {15'h0, m_sp == 0});
    check(tag, "stk_full",  {15'h0, stk_full},  {15'h0, m_sp == 8});
    check(tag, "ovf_err",   {15'h0, ovf_err},   {15'h0, m_ovf});
    check(tag, "unf_err",   {15'h0, unf_err},   {15'h0, m_unf});
    @(posedge clk);
    model_step(a, c, wi, wd);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h1b2c3d4e));
    for (int i = 0; i < 8; i++) m_mem[i] = 16'h0;
    m_sp = 0; m_arch = A_MM; m_ovf = 1'b0; m_unf = 1'b0;
    rst_n = 1'b0; arch_sel = A_MM; cmd = C_NOP; wr_idx = 3'd0; wr_data = 16'h0;
    rd_idx_a = 3'd0; rd_idx_b = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    step("R1", A_MM, C_NOP, 3'd0, 16'h0, 3'd0, 3'd1);
    // R12: memory-to-memory and unused codes ignore commands
    step("R12", A_MM, C_WR, 3'd2, 16'hdead, 3'd2, 3'd2);
    step("R12", A_MM, C_LD, 3'd0, 16'hbeef, 3'd0, 3'd0);
    step("R12", 3'd6, C_WR, 3'd3, 16'h1111, 3'd3, 3'd3);
    step("R12", 3'd6, C_PUSH, 3'd0, 16'h2222, 3'd3, 3'd3);
    step("R12", 3'd7, C_LD, 3'd0, 16'h3333, 3'd0, 3'd0);
    step("R12", 3'd7, C_NOP, 3'd0, 16'h0, 3'd0, 3'd0);

    // R2: switch to register-memory, command in the switch cycle dropped
    step("R2", A_RM, C_WR, 3'd5, 16'h5555, 3'd5, 3'd5);
    // R3: register writes and reads on both ports
    for (int i = 0; i < 8; i++) step("R3", A_RM, C_WR, 3'(i), 16'h1000 + 16'(i), 3'd5, 3'd0);
    for (int i = 0; i < 8; i++) step("R3", A_RM, C_NOP, 3'd0, 16'h0, 3'(i), 3'(7 - i));
    // R13: stack and accumulator commands ignored in register mode
    step("R13", A_RM, C_PUSH, 3'd0, 16'hffff, 3'd0, 3'd1);
    step("R13", A_RM, C_LD, 3'd0, 16'heeee, 3'd0, 3'd0);
    step("R13", A_RM, C_POP, 3'd0, 16'h0, 3'd0, 3'd1);
    step("R13", A_RM, C_NOP, 3'd0, 16'h0, 3'd0, 3'd7);
    // R2: switch to load-store clears entry 0 only
    step("R2", A_LS, C_NOP, 3'd0, 16'h0, 3'd0, 3'd1);
    step("R2", A_LS, C_NOP, 3'd0, 16'h0, 3'd0, 3'd6);

    // R4: accumulator mode
    step("R4", A_ACC, C_NOP, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R4", A_ACC, C_LD, 3'd0, 16'habcd, 3'd3, 3'd3);
    step("R4", A_ACC, C_WR, 3'd3, 16'h7777, 3'd3, 3'd3);
    step("R13", A_ACC, C_PUSH, 3'd0, 16'h6666, 3'd0, 3'd0);
    step("R4", A_ACC, C_NOP, 3'd0, 16'h0, 3'd0, 3'd0);

    // R5: extended accumulator mode
    step("R5", A_XA, C_NOP, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R5", A_XA, C_LD, 3'd0, 16'h0a0a, 3'd0, 3'd0);
    step("R5", A_XA, C_WR, 3'd2, 16'h2b2b, 3'd0, 3'd2);
    step("R5", A_XA, C_WR, 3'd0, 16'h9999, 3'd0, 3'd2);
    step("R5", A_XA, C_WR, 3'd5, 16'h8888, 3'd0, 3'd0);
    step("R5", A_XA, C_NOP, 3'd0, 16'h0, 3'd0, 3'd5);
    step("R5", A_XA, C_NOP, 3'd0, 16'h0, 3'd0, 3'd3);

    // Stack mode
    step("R6", A_STK, C_NOP, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R10", A_STK, C_POP, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R10", A_STK, C_DUP, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R7", A_STK, C_PUSH, 3'd0, 16'h00a1, 3'd0, 3'd0);
    step("R10", A_STK, C_SWAP, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R7", A_STK, C_PUSH, 3'd0, 16'h00b2, 3'd0, 3'd0);
    step("R10", A_STK, C_ROT, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R7", A_STK, C_PUSH, 3'd0, 16'h00c3, 3'd0, 3'd0);
    step("R9", A_STK, C_ROT, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R9", A_STK, C_POP, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R9", A_STK, C_POP, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R8", A_STK, C_PUSH, 3'd0, 16'h00d4, 3'd0, 3'd0);
    step("R8", A_STK, C_SWAP, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R8", A_STK, C_DUP, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R13", A_STK, C_LD, 3'd0, 16'h4444, 3'd0, 3'd0);
    step("R13", A_STK, C_WR, 3'd1, 16'h4545, 3'd0, 3'd0);
    for (int i = 0; i < 6; i++) step("R7", A_STK, C_PUSH, 3'd0, 16'h0e00 + 16'(i), 3'd0, 3'd0);
    step("R11", A_STK, C_PUSH, 3'd0, 16'hf00d, 3'd0, 3'd0);
    step("R11", A_STK, C_DUP, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R11", A_STK, C_NOP, 3'd0, 16'h0, 3'd0, 3'd0);
    for (int i = 0; i < 8; i++) step("R7", A_STK, C_POP, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R10", A_STK, C_POP, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R2", A_STK, C_PUSH, 3'd0, 16'h1234, 3'd0, 3'd0);
    step("R2", A_RM, C_PUSH, 3'd0, 16'h0, 3'd0, 3'd0);
    step("R2", A_RM, C_NOP, 3'd0, 16'h0, 3'd1, 3'd0);

    // Constrained random phase
    begin
      logic [2:0] ra, rc;
      ra = A_STK;
      for (int n = 0; n < 4000; n++) begin
        if ($urandom_range(0, 49) == 0) ra = 3'($urandom_range(0, 7));
        rc = 3'($urandom_range(0, 7));
        if (ra == A_STK && $urandom_range(0, 3) == 0) rc = C_PUSH;
        step(tag_of(m_arch), ra, rc, 3'($urandom_range(0, 7)), 16'($urandom),
             3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
      end
    end
    step("R6", A_STK, C_NOP, 3'd0, 16'h0, 3'd0, 3'd0);

    finish_run();
  end

endmodule